// File: doc/BRIEF.md
# Serial Flash Write-Arm Gate

This block sits at the front of a serial NOR flash slave and decides whether a modifying command may reach the downstream program/erase engine. It watches a chip-select / serial-clock / data-in interface and shifts in 8-bit command codes, most significant bit first. It holds one bit of state, the write-enable latch. An arm command sets the latch and a disarm command clears it. Program, sector erase, chip erase and status-write commands are forwarded as a one-cycle strobe only while the latch is set. The engine reports the end of every operation with a completion pulse, and that pulse clears the latch. Each modifying operation therefore needs a fresh arm command.

All serial inputs are sampled on the system clock `clk` and are assumed to be synchronised already. A serial-clock rising edge is recognised when the sampled `spi_sck` goes from 0 to 1 while `spi_cs_n` is low. The block never drives the serial output. The latch is brought out on `wr_latch` so that it can be placed in bit 1 of a status register.

Top module: `spi_wel_ctrl`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), `wr_latch` is 0 and `cmd_valid` is 0.
- R2: A frame of exactly 8 serial-clock rising edges that carries code 0x06 (arm), sent MSB first, sets `wr_latch` in the cycle after the one in which `spi_cs_n` is first sampled high.
- R3: An exactly framed code 0x04 (disarm) clears `wr_latch` in the cycle after `spi_cs_n` is sampled high.
- R4: An arm or disarm frame that has fewer or more than 8 serial-clock rising edges is discarded, and `wr_latch` keeps its value.
- R5: With `wr_latch` at 1 and `eng_busy` at 0, a modifying code raises `cmd_valid` for exactly one cycle, in the cycle after the 8th serial-clock rising edge is sampled. `cmd_kind` gives the command: 0 for program (0x02), 1 for sector erase (0xD8), 2 for chip erase (0xC7), 3 for status write (0x01).
- R6: A modifying code received while `wr_latch` is 0 produces no `cmd_valid` pulse.
- R7: An `eng_done` pulse clears `wr_latch` in the next cycle. This takes priority over an arm frame that ends in the same cycle.
- R8: While `eng_busy` is 1, arm and disarm frames leave `wr_latch` unchanged and modifying codes produce no `cmd_valid`.
- R9: `spi_miso_oe` stays 0 at all times, so the serial output is high-impedance.
- R10: Any other code (for example 0x05 or 0x03) changes neither `wr_latch` nor `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, sampled on clk |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out value (unused, 0) |
| spi_miso_oe | output | 1 | Serial data out enable, always 0 |
| eng_busy | input | 1 | Downstream engine is busy |
| eng_done | input | 1 | One-cycle pulse from the engine: operation finished |
| cmd_valid | output | 1 | One-cycle strobe for a modifying command |
| cmd_kind | output | 2 | Kind of modifying command, valid with cmd_valid |
| wr_latch | output | 1 | Write-enable latch |

## Verification
Two situations are hard to reach from the ports. The first is a completion pulse that lands in the very cycle in which an arm frame closes. The second is a frame that misses the 8-edge count by exactly one edge, in either direction. The frame task takes an edge count and a flag that raises `eng_done` on the chip-select rising cycle, so both cases are driven on purpose. A behavioural model keeps the received bits in a queue and is compared against the design on every clock.

// File: rtl/spi_wel_pkg.sv
package spi_wel_pkg;

    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_ARM      = 8'h06;
    localparam logic [OPC_W-1:0] OPC_DISARM   = 8'h04;
    localparam logic [OPC_W-1:0] OPC_PROGRAM  = 8'h02;
    localparam logic [OPC_W-1:0] OPC_SEC_ERS  = 8'hD8;
    localparam logic [OPC_W-1:0] OPC_CHIP_ERS = 8'hC7;
    localparam logic [OPC_W-1:0] OPC_STAT_WR  = 8'h01;

    typedef enum logic [1:0] {
        MOD_PROGRAM  = 2'd0,
        MOD_SEC_ERS  = 2'd1,
        MOD_CHIP_ERS = 2'd2,
        MOD_STAT_WR  = 2'd3
    } mod_kind_e;

    typedef struct packed {
        logic      arm;
        logic      disarm;
        logic      modify;
        mod_kind_e kind;
    } dec_t;

endpackage

// File: rtl/spi_wel_shift.sv
module spi_wel_shift #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cs_n,
    input  logic            sck,
    input  logic            mosi,
    output logic            byte_done,
    output logic [BITS-1:0] byte_val,
    output logic            frame_end,
    output logic            frame_exact,
    output logic [BITS-1:0] frame_byte
);
    localparam int CNT_W = $clog2(BITS + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BITS);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(BITS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BITS - 1);

    typedef struct packed {
        logic            sck;
        logic            cs_n;
        logic [CNT_W-1:0] cnt;
        logic [BITS-1:0] sh;
    } shift_t;

    shift_t st_q, st_d;
    logic   sck_rise;

    always_comb begin
        sck_rise    = sck && !st_q.sck && !cs_n;
        byte_done   = sck_rise && (st_q.cnt == CNT_LAST);
        byte_val    = {st_q.sh[BITS-2:0], mosi};
        frame_end   = cs_n && !st_q.cs_n;
        frame_exact = (st_q.cnt == CNT_FULL);
        frame_byte  = st_q.sh;

        st_d      = st_q;
        st_d.sck  = sck;
        st_d.cs_n = cs_n;
        if (cs_n) begin
            st_d.cnt = '0;
        end else if (sck_rise) begin
            st_d.sh = {st_q.sh[BITS-2:0], mosi};
            if (st_q.cnt != CNT_SAT) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sck: 1'b0, cs_n: 1'b1, cnt: '0, sh: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/spi_wel_decode.sv
module spi_wel_decode
    import spi_wel_pkg::*;
(
    input  logic [OPC_W-1:0] code,
    output dec_t             dec
);
    always_comb begin
        dec        = '0;
        dec.kind   = MOD_PROGRAM;
        dec.arm    = (code == OPC_ARM);
        dec.disarm = (code == OPC_DISARM);
        unique case (code)
            OPC_PROGRAM:  begin dec.modify = 1'b1; dec.kind = MOD_PROGRAM;  end
            OPC_SEC_ERS:  begin dec.modify = 1'b1; dec.kind = MOD_SEC_ERS;  end
            OPC_CHIP_ERS: begin dec.modify = 1'b1; dec.kind = MOD_CHIP_ERS; end
            OPC_STAT_WR:  begin dec.modify = 1'b1; dec.kind = MOD_STAT_WR;  end
            default:      dec.modify = 1'b0;
        endcase
    end
endmodule

// File: rtl/spi_wel_ctrl.sv
module spi_wel_ctrl
    import spi_wel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_mosi,
    output logic       spi_miso,
    output logic       spi_miso_oe,
    input  logic       eng_busy,
    input  logic       eng_done,
    output logic       cmd_valid,
    output logic [1:0] cmd_kind,
    output logic       wr_latch
);
    localparam int NDEC = 2;  // 0: byte just completed, 1: byte at frame end

    typedef struct packed {
        logic      latch;
        logic      valid;
        mod_kind_e kind;
    } ctrl_t;

    ctrl_t ctl_q, ctl_d;

    logic             byte_done, frame_end, frame_exact;
    logic [OPC_W-1:0] byte_val, frame_byte;
    logic [OPC_W-1:0] dec_in [NDEC];
    dec_t             dec_out [NDEC];

    spi_wel_shift #(.BITS(OPC_W)) i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .mosi       (spi_mosi),
        .byte_done  (byte_done),
        .byte_val   (byte_val),
        .frame_end  (frame_end),
        .frame_exact(frame_exact),
        .frame_byte (frame_byte)
    );

    assign dec_in[0] = byte_val;
    assign dec_in[1] = frame_byte;

    for (genvar g = 0; g < NDEC; g++) begin : g_dec
        spi_wel_decode i_dec (
            .code(dec_in[g]),
            .dec (dec_out[g])
        );
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.valid = 1'b0;
        if (byte_done && dec_out[0].modify && ctl_q.latch && !eng_busy) begin
            ctl_d.valid = 1'b1;
            ctl_d.kind  = dec_out[0].kind;
        end
        if (frame_end && frame_exact && !eng_busy) begin
            if (dec_out[1].arm)    ctl_d.latch = 1'b1;
            if (dec_out[1].disarm) ctl_d.latch = 1'b0;
        end
        if (eng_done) begin
            ctl_d.latch = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{latch: 1'b0, valid: 1'b0, kind: MOD_PROGRAM};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wr_latch    = ctl_q.latch;
    assign cmd_valid   = ctl_q.valid;
    assign cmd_kind    = ctl_q.kind;
    assign spi_miso    = 1'b0;
    assign spi_miso_oe = 1'b0;

endmodule

// File: rtl/spi_wel_chk.sv
module spi_wel_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_cs_n,
    input logic eng_busy,
    input logic eng_done,
    input logic cmd_valid,
    input logic wr_latch
);
    AST_RESET_CLEAR: assert property (@(posedge clk) $rose(rst_n) |-> !wr_latch && !cmd_valid); // R1
    AST_LATCH_RISE_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_latch) |-> $past(spi_cs_n) && !$past(eng_busy) && !$past(eng_done)); // R2
    AST_STROBE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(wr_latch) && !$past(eng_busy)); // R6
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid); // R5
    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !wr_latch); // R7
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_busy && !eng_done) |=> $stable(wr_latch)); // R8
endmodule

bind spi_wel_ctrl spi_wel_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_cs_n (spi_cs_n),
    .eng_busy (eng_busy),
    .eng_done (eng_done),
    .cmd_valid(cmd_valid),
    .wr_latch (wr_latch)
);

// File: tb/test_spi_wel_ctrl.sv
`timescale 1ns/1ps
module test_spi_wel_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic eng_busy = 1'b0, eng_done = 1'b0;
    logic spi_miso, spi_miso_oe, cmd_valid, wr_latch;
    logic [1:0] cmd_kind;

    int checks = 0, fails = 0, strobes = 0;
    logic [1:0] last_kind = 2'd0;

    always #4 clk = ~clk;  // 125 MHz

    spi_wel_ctrl i_spi_wel_ctrl (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .eng_busy(eng_busy), .eng_done(eng_done), .cmd_valid(cmd_valid),
        .cmd_kind(cmd_kind), .wr_latch(wr_latch)
    );

    // Behavioural reference model
    bit   rx_bits[$];
    logic m_latch = 1'b0, m_valid = 1'b0;
    logic [1:0] m_kind = 2'd0;
    logic prev_sck = 1'b0, prev_cs = 1'b1;

    function automatic logic [7:0] pack_bits();
        logic [7:0] v = '0;
        for (int i = 0; i < 8; i++) v = {v[6:0], rx_bits[i]};
        return v;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_latch = 1'b0; m_valid = 1'b0; m_kind = 2'd0;
            rx_bits.delete(); prev_sck = 1'b0; prev_cs = 1'b1;
        end else begin
            logic nl;
            logic [7:0] b;
            nl = m_latch;
            m_valid = 1'b0;
            if (!spi_cs_n && spi_sck && !prev_sck) begin
                rx_bits.push_back(spi_mosi);
                if (rx_bits.size() == 8 && m_latch && !eng_busy) begin
                    b = pack_bits();
                    case (b)
                        8'h02: begin m_valid = 1'b1; m_kind = 2'd0; end
                        8'hD8: begin m_valid = 1'b1; m_kind = 2'd1; end
                        8'hC7: begin m_valid = 1'b1; m_kind = 2'd2; end
                        8'h01: begin m_valid = 1'b1; m_kind = 2'd3; end
                        default: ;
                    endcase
                end
            end
            if (spi_cs_n && !prev_cs && rx_bits.size() == 8 && !eng_busy) begin
                b = pack_bits();
                if (b == 8'h06) nl = 1'b1;
                if (b == 8'h04) nl = 1'b0;
            end
            if (spi_cs_n) rx_bits.delete();
            if (eng_done) nl = 1'b0;
            m_latch = nl;
            prev_sck = spi_sck;
            prev_cs = spi_cs_n;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            check("R2/R3/R7 wr_latch vs model", wr_latch, m_latch);
            check("R5/R6 cmd_valid vs model", cmd_valid, m_valid);
            if (m_valid) check("R5 cmd_kind vs model", cmd_kind, m_kind);
            check("R9 miso_oe low", spi_miso_oe, 0);
            if (cmd_valid) begin strobes++; last_kind = cmd_kind; end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] code, input int nedges, input logic done_at_end);
        @(negedge clk) spi_cs_n = 1'b0;
        idle(1);
        for (int i = 0; i < nedges; i++) begin
            spi_mosi = (i < 8) ? code[7-i] : 1'b0;
            spi_sck = 1'b0;
            idle(2);
            spi_sck = 1'b1;
            idle(2);
        end
        spi_sck = 1'b0;
        idle(2);
        spi_cs_n = 1'b1;
        eng_done = done_at_end;
        idle(1);
        eng_done = 1'b0;
        idle(3);
    endtask

    initial begin
        #20000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int s0;
        idle(3);
        check("R1 reset latch", wr_latch, 0);
        check("R1 reset strobe", cmd_valid, 0);
        rst_n = 1'b1;
        idle(2);
        check("R1 latch after release", wr_latch, 0);

        s0 = strobes;
        frame(8'hD8, 8, 1'b0);
        check("R6 no strobe when disarmed", strobes - s0, 0);

        frame(8'h06, 8, 1'b0);
        check("R2 arm sets latch", wr_latch, 1);

        s0 = strobes;
        frame(8'h02, 8, 1'b0);
        check("R5 program strobe", strobes - s0, 1);
        check("R5 program kind", last_kind, 0);
        frame(8'hD8, 8, 1'b0);
        check("R5 sector erase kind", last_kind, 1);
        frame(8'hC7, 8, 1'b0);
        check("R5 chip erase kind", last_kind, 2);
        frame(8'h01, 8, 1'b0);
        check("R5 status write kind", last_kind, 3);
        check("R5 four strobes total", strobes - s0, 4);

        s0 = strobes;
        frame(8'h05, 8, 1'b0);
        frame(8'h03, 8, 1'b0);
        check("R10 other codes keep latch", wr_latch, 1);
        check("R10 other codes no strobe", strobes - s0, 0);

        @(negedge clk) eng_done = 1'b1;
        @(negedge clk) eng_done = 1'b0;
        check("R7 done clears latch", wr_latch, 0);

        frame(8'h06, 7, 1'b0);
        check("R4 short arm frame discarded", wr_latch, 0);
        frame(8'h06, 9, 1'b0);
        check("R4 long arm frame discarded", wr_latch, 0);
        frame(8'h06, 8, 1'b0);
        frame(8'h04, 9, 1'b0);
        check("R4 long disarm frame discarded", wr_latch, 1);
        frame(8'h04, 7, 1'b0);
        check("R4 short disarm frame discarded", wr_latch, 1);
        frame(8'h04, 8, 1'b0);
        check("R3 disarm clears latch", wr_latch, 0);

        frame(8'h06, 8, 1'b1);
        check("R7 done wins over arm", wr_latch, 0);

        frame(8'h06, 8, 1'b0);
        eng_busy = 1'b1;
        s0 = strobes;
        frame(8'h04, 8, 1'b0);
        check("R8 disarm ignored while busy", wr_latch, 1);
        frame(8'h02, 8, 1'b0);
        check("R8 no strobe while busy", strobes - s0, 0);
        eng_busy = 1'b0;
        frame(8'h04, 8, 1'b0);
        eng_busy = 1'b1;
        frame(8'h06, 8, 1'b0);
        check("R8 arm ignored while busy", wr_latch, 0);
        eng_busy = 1'b0;

        check("R9 miso enable low", spi_miso_oe, 0);
        idle(4);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule